// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. Every part of it runs on the divided input clock. A dual-modulus stage divides by 10 or 11. A swallow counter picks the modulus for the first few stage periods of each output cycle. A main counter counts complete stage periods. The total ratio is therefore 10*(M+1)+A input clocks for each output pulse. A single programmable counter would need the whole ratio to run at the input rate; here only the small stage and the swallow decision do.

A bypass control takes the dual-modulus stage out of the path and holds the swallow counter idle. The main counter then counts input clocks directly, which gives a ratio of M+1. The divide values M and A and the bypass control are plain level inputs. The divider samples them only on the last clock of an output cycle, so every cycle uses one complete ratio. There is no streaming data path, so no valid/ready handshake is involved: the output is a single strobe.

Top module: `swdiv_feedback`

## Requirements
- R1: With bypass_i low, 1 <= M <= 511 and 0 <= A <= M+1, pulse_o goes high once every 10*(M+1)+A input clocks.
- R2: The swallow count forces modulus 11 for min(A, M+1) stage periods per cycle. A = M+1 therefore gives 11*(M+1) clocks per pulse, and A > M+1 (for example M=3, A=9 or M=5, A=15) also gives 11*(M+1).
- R3: With bypass_i high, pulse_o goes high once every M+1 input clocks, so M=1 gives a pulse every 2 clocks.
- R4: pulse_o is high for exactly one input clock, the last clock of each output cycle, whenever the ratio exceeds 1.
- R5: rst_i is synchronous and active high. While it is applied with M >= 1, pulse_o is low. The clock on which rst_i is first sampled low counts as clock 1, and the first pulse falls on clock N of the ratio then applied.
- R6: div_m_i, div_a_i and bypass_i are sampled on the clock where pulse_o is high (and during reset), and they set the ratio of the following cycle. A change on any other clock has no effect on the cycle in progress.
- R7: At the minimum M of 1, the ratio is 20+A in normal mode (20 for A=0, 22 for A=2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| div_m_i | input | 9 | Main count M (ratio term M+1) |
| div_a_i | input | 4 | Swallow count A (periods at modulus 11) |
| bypass_i | input | 1 | High: dual-modulus stage and swallow counter idle, ratio M+1 |
| pulse_o | output | 1 | One-clock strobe on the last clock of each output cycle |

## Verification
The end of an output cycle and a change of the divide inputs can land on the same clock. The sweep provokes this on purpose: each new M, A and bypass setting is driven while pulse_o is high, and the next cycle's length must match the new setting exactly. A second case changes the inputs a few clocks into a cycle. The length of that cycle must still follow the old setting, and only the cycle after it may follow the new one. A reset applied in the middle of a cycle is judged the same way, by the length to the first pulse after it.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Default sizing of the divider
  localparam int unsigned SWDIV_M_W    = 9;   // main counter width
  localparam int unsigned SWDIV_A_W    = 4;   // swallow counter width
  localparam int unsigned SWDIV_PRE_LO = 10;  // low modulus; high is this plus one

  // Modulus choice handed from the swallow counter to the stage
  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } swdiv_mod_e;
endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
#(
  parameter int unsigned PRE_LO = SWDIV_PRE_LO
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       restart_i,  // output-cycle boundary
  input  logic       idle_i,     // bypass: stage held
  input  swdiv_mod_e mod_i,
  output logic       term_o      // last clock of a stage period
);
  localparam int unsigned PC_W = $clog2(PRE_LO + 1);
  localparam logic [PC_W-1:0] LAST_LO = PC_W'(PRE_LO - 1);
  localparam logic [PC_W-1:0] LAST_HI = PC_W'(PRE_LO);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] last_cnt;

  assign last_cnt = (mod_i == MOD_HI) ? LAST_HI : LAST_LO;
  assign term_o   = !idle_i && (pc_q == last_cnt);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i || idle_i) begin
      pc_q <= '0;
    end else if (term_o) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  // R1: at modulus 10 the stage count never reaches 10
  assert_presc_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (mod_i == MOD_LO) |-> (pc_q < LAST_HI));

  // R3: in bypass the stage stays parked at zero
  assert_presc_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    idle_i |-> (pc_q == '0));
endmodule

// File: rtl/swdiv_swallow_ctr.sv
module swdiv_swallow_ctr
  import swdiv_pkg::*;
#(
  parameter int unsigned A_W = SWDIV_A_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           load_i,   // output-cycle boundary
  input  logic [A_W-1:0] a_i,      // new swallow count
  input  logic           idle_i,   // bypass
  input  logic           step_i,   // one stage period completed
  output swdiv_mod_e     mod_o
);
  logic [A_W-1:0] ac_q;

  assign mod_o = (!idle_i && (ac_q != '0)) ? MOD_HI : MOD_LO;

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) begin
      ac_q <= a_i;
    end else if (step_i && !idle_i && (ac_q != '0)) begin
      ac_q <= ac_q - 1'b1;
    end
  end

  // R2: each completed stage period at modulus 11 uses up one swallow count
  assert_swallow_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && step_i && !idle_i && (ac_q != '0)) |=> (ac_q == $past(ac_q) - 1'b1));
endmodule

// File: rtl/swdiv_main_ctr.sv
module swdiv_main_ctr
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W = SWDIV_M_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           restart_i,
  input  logic           step_i,
  input  logic [M_W-1:0] m_i,      // active M
  output logic           last_o    // count has reached M
);
  logic [M_W-1:0] mc_q;

  assign last_o = (mc_q == m_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) begin
      mc_q <= '0;
    end else if (step_i) begin
      mc_q <= mc_q + 1'b1;
    end
  end

  // R1: the main count never passes the active M
  assert_main_bound_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    mc_q <= m_i);
endmodule

// File: rtl/swdiv_cfg_latch.sv
module swdiv_cfg_latch
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W = SWDIV_M_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           load_i,
  input  logic [M_W-1:0] m_i,
  input  logic           bypass_i,
  output logic [M_W-1:0] m_o,
  output logic           bypass_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i || load_i) begin
      m_o      <= m_i;
      bypass_o <= bypass_i;
    end
  end

  // R6: the active setting moves only at a boundary
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> ($stable(m_o) && $stable(bypass_o)));
endmodule

// File: rtl/swdiv_feedback.sv
module swdiv_feedback
  import swdiv_pkg::*;
#(
  parameter int unsigned M_W    = SWDIV_M_W,
  parameter int unsigned A_W    = SWDIV_A_W,
  parameter int unsigned PRE_LO = SWDIV_PRE_LO
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [M_W-1:0] div_m_i,
  input  logic [A_W-1:0] div_a_i,
  input  logic           bypass_i,
  output logic           pulse_o
);
  logic [M_W-1:0] m_q;
  logic           byp_q;
  logic           presc_term;
  logic           main_step;
  logic           main_last;
  swdiv_mod_e     mod_sel;

  // In bypass the main counter advances on every input clock
  assign main_step = byp_q ? 1'b1 : presc_term;
  assign pulse_o   = main_step && main_last;

  swdiv_cfg_latch #(.M_W(M_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (pulse_o),
    .m_i      (div_m_i),
    .bypass_i (bypass_i),
    .m_o      (m_q),
    .bypass_o (byp_q)
  );

  swdiv_prescaler #(.PRE_LO(PRE_LO)) u_presc (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (pulse_o),
    .idle_i    (byp_q),
    .mod_i     (mod_sel),
    .term_o    (presc_term)
  );

  swdiv_swallow_ctr #(.A_W(A_W)) u_swallow (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (pulse_o),
    .a_i    (div_a_i),
    .idle_i (byp_q),
    .step_i (presc_term),
    .mod_o  (mod_sel)
  );

  swdiv_main_ctr #(.M_W(M_W)) u_main (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (pulse_o),
    .step_i    (main_step),
    .m_i       (m_q),
    .last_o    (main_last)
  );

  // R4: a pulse is one clock wide unless the next ratio is 1
  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (pulse_o && !(bypass_i && (div_m_i == '0))) |=> !pulse_o);
endmodule

// File: tb/swdiv_feedback_tb_top.sv
module swdiv_feedback_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_i = 1'b1;
  logic [8:0] div_m_i = '0;
  logic [3:0] div_a_i = '0;
  logic       bypass_i = 1'b0;
  logic       pulse_o;

  int vecs = 0;
  int miss = 0;
  int n;

  always #5 clk_i = ~clk_i;

  swdiv_feedback dut_i (
    .clk_i(clk_i), .rst_i(rst_i), .div_m_i(div_m_i),
    .div_a_i(div_a_i), .bypass_i(bypass_i), .pulse_o(pulse_o)
  );

  function automatic int ratio(int m, int a, bit b);
    if (b) return m + 1;
    if (a > m + 1) return 11 * (m + 1);
    return 10 * (m + 1) + a;
  endfunction

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(int m, int a, bit b);
    div_m_i  = 9'(m);
    div_a_i  = 4'(a);
    bypass_i = b;
  endtask

  // Counts clocks from the current one up to and including the pulse clock
  task automatic wait_pulse(output int cnt);
    cnt = 0;
    while (1) begin
      cnt++;
      if (pulse_o) break;
      if (cnt > 8000) begin
        miss++;
        $display("FAIL watchdog: no pulse after %0d clocks", cnt);
        break;
      end
      @(negedge clk_i);
    end
  endtask

  // Called on a pulse clock: new setting applies to the next cycle
  task automatic next_period(int m, int a, bit b, string req);
    int k;
    set_cfg(m, a, b);
    @(negedge clk_i);
    if (ratio(m, a, b) > 1) check("R4 low after pulse", int'(pulse_o), 0);
    wait_pulse(k);
    check(req, k, ratio(m, a, b));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    miss++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R5: reset holds output low, first pulse after one full ratio
    set_cfg(3, 2, 1'b0);
    repeat (3) @(negedge clk_i);
    check("R5 pulse low in reset", int'(pulse_o), 0);
    rst_i = 1'b0;
    wait_pulse(n);
    check("R5 first pulse", n, 42);

    // R1: sweep of normal mode, new value applied on the pulse clock
    for (int m = 1; m <= 20; m++) begin
      for (int a = 0; a <= ((m + 1 < 15) ? m + 1 : 15); a++) begin
        next_period(m, a, 1'b0, "R1 normal ratio");
      end
    end
    next_period(511, 0, 1'b0, "R1 max M A=0");
    next_period(511, 15, 1'b0, "R1 max M A=15");

    // R2: all stage periods at modulus 11
    next_period(14, 15, 1'b0, "R2 A=M+1");
    next_period(3, 9, 1'b0, "R2 A above M+1");
    next_period(5, 15, 1'b0, "R2 A=15 above M+1");

    // R7: minimum M
    next_period(1, 0, 1'b0, "R7 M=1 A=0");
    next_period(1, 2, 1'b0, "R7 M=1 A=2");

    // R3: bypass sweep
    for (int m = 1; m <= 40; m++) next_period(m, 9, 1'b1, "R3 bypass ratio");
    next_period(511, 3, 1'b1, "R3 bypass max M");
    next_period(1, 0, 1'b1, "R3 bypass M=1");
    next_period(6, 1, 1'b0, "R3 leave bypass");

    // R6: change mid-cycle is ignored until the boundary
    set_cfg(7, 3, 1'b0);
    @(negedge clk_i);
    repeat (5) @(negedge clk_i);
    set_cfg(2, 1, 1'b0);
    wait_pulse(n);
    check("R6 mid-cycle change ignored", n + 5, 83);
    @(negedge clk_i);
    wait_pulse(n);
    check("R6 change applied next cycle", n, 31);

    // R6: bypass toggled mid-cycle is ignored
    set_cfg(4, 2, 1'b0);
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    set_cfg(4, 2, 1'b1);
    wait_pulse(n);
    check("R6 mid-cycle bypass ignored", n + 3, 52);
    @(negedge clk_i);
    wait_pulse(n);
    check("R6 bypass applied next cycle", n, 5);

    // R5: reset in the middle of a cycle restarts counting
    set_cfg(4, 1, 1'b0);
    @(negedge clk_i);
    repeat (7) @(negedge clk_i);
    rst_i = 1'b1;
    set_cfg(6, 4, 1'b0);
    repeat (2) @(negedge clk_i);
    check("R5 pulse low in mid reset", int'(pulse_o), 0);
    rst_i = 1'b0;
    wait_pulse(n);
    check("R5 first pulse after mid reset", n, 74);

    finish_run();
  end
endmodule